// File: doc/BRIEF.md
# Transmit Byte Buffer with Refill Interrupt

This block sits between a host write port and a transmit serializer. The host first loads the number of bytes the next frame carries, then pushes data bytes into a 24-entry byte buffer. The frame starts by itself as soon as the first data byte lands in the buffer. From then on, the serializer pulls bytes on request until the loaded length is used up. The length may be larger than the buffer. The host streams in the rest when a refill interrupt tells it that only a few bytes are left in storage.

Four interrupt causes are kept as pending bits:
- frame done,
- buffer running low,
- host write dropped because the buffer was full,
- serializer request that found the buffer empty.

A status read returns the pending bits and clears them. The interrupt line is the OR of the pending bits that the host has enabled. A flush command code empties the buffer and abandons the frame in progress.

Top module: `tx_refill_fifo`

## Requirements
- R1: After reset the interrupt line is low, the status read value is 0, and a serializer request gets no acknowledge.
- R2: Bytes reach `serData` in the order they were written, and up to 24 bytes are held at once.
- R3: After a length is loaded, serializer requests get no acknowledge and raise no cause until the first data byte has been written.
- R4: Exactly the loaded number of bytes is handed out per frame. Further requests get no acknowledge, even while bytes remain in the buffer. Loading a new length abandons the current frame.
- R5: Status bit 1 (low) is set when a handout leaves exactly 3 bytes in the buffer and the frame still needs more than 3 bytes.
- R6: Status bit 0 (done) is set in the cycle after the last byte of the frame is handed out.
- R7: `statRdData` shows the pending bits. A cycle with `statRdEn` high clears them, except a cause raised in that same cycle, which stays pending.
- R8: A host write while 24 bytes are held is dropped and sets status bit 2 (overflow).
- R9: A request during a started frame with an empty buffer sets status bit 3 (underflow).
- R10: Command code 0x8F empties the buffer, clears the length and stops the frame, without raising any cause. Other command codes have no effect.
- R11: `irq` is high exactly when some pending bit is set whose `irqMask` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Push one data byte |
| hostWrData | input | 8 | Data byte to push |
| lenWrEn | input | 1 | Load the frame length |
| lenWrData | input | 8 | Frame length in bytes |
| cmdEn | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code (0x8F flushes) |
| statRdEn | input | 1 | Status read strobe; clears pending bits |
| statRdData | output | 4 | Pending causes: bit0 done, bit1 low, bit2 overflow, bit3 underflow |
| irqMask | input | 4 | Per-cause interrupt enable |
| irq | output | 1 | Interrupt request |
| serReq | input | 1 | Serializer asks for a byte |
| serAck | output | 1 | A byte is handed out this cycle |
| serData | output | 8 | Byte handed out |

## Verification
Directed frames cover three cases:
- a frame shorter than the buffer, which separates the done cause from the low cause;
- a frame longer than its initial fill, which shows the low cause firing only on the handout that leaves 3 bytes while more are owed;
- an overfilled 30-byte frame, which drains into an underflow.

Other directed cases cover a flush with a foreign command code before it, a length smaller than the buffered data, and a status read that collides with a done event.

A long random run then mixes pushes, pulls, length loads, flushes, reads and mask changes. Every cycle is compared with a bench model of the requirements. This catches ordering errors, counter drift and wrongly cleared causes under interleavings the directed cases do not reach.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int CAUSE_N   = 4;
  localparam int CAUSE_EOT = 0;
  localparam int CAUSE_LOW = 1;
  localparam int CAUSE_OVF = 2;
  localparam int CAUSE_UNF = 3;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrPtrNext, rdPtrNext;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wrPtrNext = wrPtr + 1'b1;
      assign rdPtrNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrPtrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtrNext;
      if (strobe.pop)  rdPtr <= rdPtrNext;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

  // R2: storage never holds more than its depth
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8: an accepted push never lands in a full buffer
  assert_push_room_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> count < CNT_W'(DEPTH));

  // R10: a flush leaves the buffer empty
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> count == '0);
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int DEPTH        = 24,
  parameter int LEN_W        = 8,
  parameter int LOW_MARK     = 3,
  parameter logic [7:0] FLUSH_CODE = 8'h8F,
  localparam int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               lenWrEn,
  input  logic [LEN_W-1:0]   lenWrData,
  input  logic               cmdEn,
  input  logic [7:0]         cmdCode,
  input  logic               statRdEn,
  input  logic [CAUSE_N-1:0] irqMask,
  input  logic               serReq,
  input  logic [CNT_W-1:0]   count,
  output fifoStrobe_t        strobe,
  output logic               serAck,
  output logic [CAUSE_N-1:0] pending,
  output logic               irq
);
  logic [LEN_W-1:0]   lenRemain;
  logic               started;
  logic               isFull, isEmpty, flushHit, pushOk, popOk, lastByte;
  logic [CAUSE_N-1:0] events;

  assign isFull   = (count == CNT_W'(DEPTH));
  assign isEmpty  = (count == '0);
  assign flushHit = cmdEn && (cmdCode == FLUSH_CODE);
  assign pushOk   = hostWrEn && !isFull && !flushHit;
  assign popOk    = serReq && started && !isEmpty && !flushHit;
  assign lastByte = (lenRemain == LEN_W'(1));

  always_comb begin
    strobe.push  = pushOk;
    strobe.pop   = popOk;
    strobe.flush = flushHit;
  end

  assign serAck = popOk;

  always_comb begin
    events = '0;
    events[CAUSE_EOT] = popOk && lastByte;
    events[CAUSE_LOW] = popOk && !pushOk
                        && (count == CNT_W'(LOW_MARK + 1))
                        && (lenRemain > LEN_W'(LOW_MARK + 1));
    events[CAUSE_OVF] = hostWrEn && isFull && !flushHit;
    events[CAUSE_UNF] = serReq && started && isEmpty && !flushHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenRemain <= '0;
      started   <= 1'b0;
    end else if (flushHit) begin
      lenRemain <= '0;
      started   <= 1'b0;
    end else if (lenWrEn) begin
      lenRemain <= lenWrData;
      started   <= 1'b0;
    end else begin
      if (popOk) lenRemain <= lenRemain - 1'b1;
      if (popOk && lastByte)                     started <= 1'b0;
      else if (pushOk && lenRemain != '0)        started <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= (statRdEn ? '0 : pending) | events;
  end

  assign irq = |(pending & irqMask);

  // R4: each handout consumes one unit of the length
  assert_len_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    serAck && !lenWrEn |=> lenRemain == $past(lenRemain) - 1'b1);

  // R6: handing out the final byte raises done, even under a status read
  assert_eot_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    serAck && lastByte && !lenWrEn |=> pending[CAUSE_EOT]);

  // R7: a read with no new event leaves nothing pending
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    statRdEn && !serReq && !hostWrEn |=> pending == '0);

  // R11: nothing pending means no interrupt
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    pending == '0 |-> !irq);
endmodule

// File: rtl/tx_refill_fifo.sv
module tx_refill_fifo
  import txr_pkg::*;
#(
  parameter int DEPTH    = 24,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 8,
  parameter int LOW_MARK = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic               lenWrEn,
  input  logic [LEN_W-1:0]   lenWrData,
  input  logic               cmdEn,
  input  logic [7:0]         cmdCode,
  input  logic               statRdEn,
  output logic [CAUSE_N-1:0] statRdData,
  input  logic [CAUSE_N-1:0] irqMask,
  output logic               irq,
  input  logic               serReq,
  output logic               serAck,
  output logic [DATA_W-1:0]  serData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobe_t      strobe;
  logic [CNT_W-1:0] count;

  txr_ctrl #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .LOW_MARK(LOW_MARK), .FLUSH_CODE(8'h8F)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .lenWrEn(lenWrEn),
    .lenWrData(lenWrData), .cmdEn(cmdEn), .cmdCode(cmdCode),
    .statRdEn(statRdEn), .irqMask(irqMask), .serReq(serReq), .count(count),
    .strobe(strobe), .serAck(serAck), .pending(statRdData), .irq(irq)
  );

  txr_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(hostWrData),
    .rdData(serData), .count(count)
  );
endmodule

// File: tb/tx_refill_fifo_bench.sv
module tx_refill_fifo_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic hostWrEn = 0, lenWrEn = 0, cmdEn = 0, statRdEn = 0, serReq = 0;
  logic [7:0] hostWrData = 0, lenWrData = 0, cmdCode = 0, serData;
  logic [3:0] irqMask = 4'hF, statRdData;
  logic irq, serAck;

  int checks = 0, failures = 0;
  logic [7:0] mq[$];
  int mLen = 0;
  bit mStarted = 0;
  logic [3:0] mPend = 0;
  logic lastAck;
  logic [7:0] lastData;

  always #5 clk = ~clk;

  tx_refill_fifo u_tx_refill_fifo (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData), .cmdEn(cmdEn), .cmdCode(cmdCode),
    .statRdEn(statRdEn), .statRdData(statRdData), .irqMask(irqMask), .irq(irq),
    .serReq(serReq), .serAck(serAck), .serData(serData)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expIrq(logic [3:0] pend, logic [3:0] mask);
    return |(pend & mask);
  endfunction

  // one cycle: drive at negedge, compare with model, advance model at the edge
  task automatic step(bit wr, logic [7:0] wd, bit lw, logic [7:0] ld,
                      bit ce, logic [7:0] cc, bit rd, bit req);
    bit full, empty, flush, push, pop, expAck;
    logic [3:0] ev;
    @(negedge clk);
    hostWrEn = wr; hostWrData = wd; lenWrEn = lw; lenWrData = ld;
    cmdEn = ce; cmdCode = cc; statRdEn = rd; serReq = req;
    full  = (mq.size() == 24);
    empty = (mq.size() == 0);
    flush = ce && (cc == 8'h8F);
    push  = wr && !full && !flush;
    pop   = req && mStarted && !empty && !flush;
    expAck = pop;
    #1;
    chk("R4 serAck", serAck, expAck);
    if (expAck) chk("R2 serData", serData, mq[0]);
    chk("R7 status", statRdData, mPend);
    chk("R11 irq", irq, expIrq(mPend, irqMask));
    lastAck = serAck; lastData = serData;
    ev = '0;
    ev[0] = pop && (mLen == 1);
    ev[1] = pop && !push && (mq.size() == 4) && (mLen - 1 > 3);
    ev[2] = wr && full && !flush;
    ev[3] = req && mStarted && empty && !flush;
    @(posedge clk);
    mPend = (rd ? 4'b0 : mPend) | ev;
    if (flush) mq.delete();
    else begin
      if (pop)  void'(mq.pop_front());
      if (push) mq.push_back(wd);
    end
    if (flush) begin mLen = 0; mStarted = 0; end
    else if (lw) begin mLen = ld; mStarted = 0; end
    else begin
      if (pop) mLen = mLen - 1;
      if (pop && mLen == 0) mStarted = 0;
      else if (push && mLen != 0) mStarted = 1;
    end
    #1;
    hostWrEn = 0; lenWrEn = 0; cmdEn = 0; statRdEn = 0; serReq = 0;
  endtask

  task automatic chkStatus(logic [3:0] exp, string tag);
    @(negedge clk); #1;
    chk(tag, statRdData, exp);
  endtask

  task automatic wrLen(int n);   step(0, 0, 1, 8'(n), 0, 0, 0, 0); endtask
  task automatic wrByte(logic [7:0] b); step(1, b, 0, 0, 0, 0, 0, 0); endtask
  task automatic pull();         step(0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic rdStat();       step(0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic command(logic [7:0] c); step(0, 0, 0, 0, 1, c, 0, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    @(negedge clk); serReq = 1; #1;
    chk("R1 irq", irq, 0);
    chk("R1 status", statRdData, 4'b0000);
    chk("R1 serAck", serAck, 0);
    serReq = 0;

    // R3 no start before data
    wrLen(5);
    pull();
    chk("R3 no ack before data", lastAck, 0);
    chkStatus(4'b0000, "R3 no cause before data");
    for (int i = 0; i < 5; i++) wrByte(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) begin
      pull();
      chk("R2 order short frame", lastData, 8'hA0 + 8'(i));
    end
    chkStatus(4'b0001, "R6 done after short frame");
    rdStat();
    chkStatus(4'b0000, "R7 cleared by read");

    // R5 low mark on a frame longer than its fill
    wrLen(10);
    for (int i = 0; i < 6; i++) wrByte(8'h40 + 8'(i));
    pull(); pull();
    chkStatus(4'b0000, "R5 not yet low");
    pull();
    chkStatus(4'b0010, "R5 low at three left");
    irqMask = 4'b0001;
    @(negedge clk); #1; chk("R11 masked", irq, 0);
    irqMask = 4'b0010;
    @(negedge clk); #1; chk("R11 unmasked", irq, 1);
    irqMask = 4'hF;
    rdStat();
    for (int i = 0; i < 4; i++) wrByte(8'h50 + 8'(i));
    for (int i = 0; i < 7; i++) pull();
    chk("R2 last byte", lastData, 8'h53);
    chkStatus(4'b0001, "R6 done after refill");
    rdStat();

    // R7 set wins over same-cycle clear
    wrLen(1);
    wrByte(8'h77);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 ack in read cycle", lastAck, 1);
    chkStatus(4'b0001, "R7 new cause survives read");
    rdStat();

    // R8 overflow, R9 underflow
    command(8'h8F);
    wrLen(30);
    for (int i = 0; i < 25; i++) wrByte(8'(i));
    chkStatus(4'b0100, "R8 overflow");
    rdStat();
    for (int i = 0; i < 24; i++) begin
      pull();
      chk("R2 full buffer order", lastData, 8'(i));
    end
    pull();
    chk("R9 no ack when empty", lastAck, 0);
    chkStatus(4'b1010, "R9 underflow with low");
    rdStat();

    // R10 flush
    command(8'h8F);
    wrLen(5);
    wrByte(8'h11); wrByte(8'h22);
    command(8'h55);
    chkStatus(4'b0000, "R10 foreign code no cause");
    command(8'h8F);
    pull();
    chk("R10 no ack after flush", lastAck, 0);
    chkStatus(4'b0000, "R10 no underflow after flush");
    wrLen(1);
    wrByte(8'hAB);
    pull();
    chk("R10 fresh data after flush", lastData, 8'hAB);
    rdStat();

    // R4 length below buffered data
    wrLen(2);
    wrByte(8'h31); wrByte(8'h32); wrByte(8'h33);
    pull(); pull(); pull();
    chk("R4 no ack past length", lastAck, 0);
    chkStatus(4'b0001, "R4 done without underflow");
    command(8'h8F);
    rdStat();

    // random mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 999));
      if (r < 3) irqMask = 4'($urandom());
      step($urandom_range(0, 99) < 45, 8'($urandom()),
           $urandom_range(0, 99) < 2, 8'($urandom_range(1, 60)),
           $urandom_range(0, 199) < 2,
           ($urandom_range(0, 1) == 1) ? 8'h8F : 8'($urandom()),
           $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 45);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule